// File: doc/BRIEF.md
# Multi-Precision Integer Tile Multiply-Accumulate

This block computes D = A×B + C on a small integer tile held inside it. Each element of D is a 32-bit signed integer. A mode input selects how the operand words are read. A word is either four signed 8-bit elements, eight signed 4-bit elements or thirty-two 1-bit elements. In every mode the element with the lowest index sits in the least significant bits. The same 32-bit word width is kept in all modes, so the number of K elements per word grows as the precision drops. Results always accumulate at 32 bits and wrap on overflow.

A single valid/ready input stream carries the whole job, in a fixed order:
1. The M×N words of C, in row-major order.
2. For each of the KSTEPS packed K positions, the M row words of A followed by the N column words of B.

After each K position has been gathered, one cycle adds every row-by-column dot product into its accumulator. When the K loop ends, the D tile is streamed out in row-major order on a valid/ready output, with a last flag on the final element. The input stays closed until that output handshake completes. Larger matrices are built by the surrounding logic, which issues this tile operation repeatedly.

Top module: `mmac_tile`

## Requirements
- R1: After reset, outValid is low and inReady is high, so the block is waiting for the first C word.
- R2: With mode 2'b00, a word holds four signed 8-bit elements. Element e is bits [8e+7:8e]. A word pair adds the sum of the four signed products.
- R3: With mode 2'b01, a word holds eight signed 4-bit elements. Element e is bits [4e+3:4e]. A word pair adds the sum of the eight signed products.
- R4: With mode 2'b10 or 2'b11, a word holds 32 one-bit elements. A word pair adds the number of bit positions where both words hold a one.
- R5: The M×N C words, taken in row-major order, become the starting value of the accumulators. With all-zero A and B, D equals C.
- R6: Every element of D is its C value plus the dot products summed over all KSTEPS K positions. At each position, A row i is paired with B column j.
- R7: Accumulation wraps modulo 2^32 and does not saturate.
- R8: D leaves the block in row-major order, one element per output handshake. outLast is high only on element M×N−1.
- R9: While outValid is high, inReady is low. Input words offered during that time are not consumed and do not affect the next tile.
- R10: While outValid is high and outReady is low, outData and outLast hold their values.
- R11: The mode is sampled together with the first C word of a tile. Changes to the mode input later in the same tile have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Element precision, sampled with the first C word |
| inData | input | 32 | Packed C, A or B word |
| inValid | input | 1 | inData is offered |
| inReady | output | 1 | Block accepts inData this cycle |
| outData | output | 32 | D element |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | Downstream takes outData |
| outLast | output | 1 | Final D element of the tile |

## Verification
Two events can fall in the same cycle:
- the handshake of the final D element;
- an upstream source that already holds inValid high with a word for the next tile, and a different mode value.

The bench provokes this on every tile. It keeps a garbage word valid, with a flipped mode, for the whole output phase. It then stalls the output once in the middle, so the hold behaviour and the closed input overlap. The result is judged in three ways:
- inReady must be low in every output cycle;
- the data must not move while the output is stalled;
- the next tile's D must match the arithmetic expectation, which would break if the stray word or mode had been taken.

// File: rtl/mmac_pkg.sv
package mmac_pkg;

  localparam int IDX_W = 8;

  typedef struct packed {
    logic             latchMode;
    logic             loadC;
    logic             capA;
    logic             capB;
    logic             accum;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  // Dot product of one packed word pair in the selected precision
  function automatic logic [31:0] dotWord(input logic [1:0] md,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
    logic signed [31:0] s;
    int p;
    s = '0;
    if (md == 2'b00) begin
      for (int e = 0; e < 4; e++) begin
        p = int'($signed(a[8*e +: 8])) * int'($signed(b[8*e +: 8]));
        s = s + p;
      end
    end else if (md == 2'b01) begin
      for (int e = 0; e < 8; e++) begin
        p = int'($signed(a[4*e +: 4])) * int'($signed(b[4*e +: 4]));
        s = s + p;
      end
    end else begin
      s = $countones(a & b);
    end
    return s;
  endfunction

endpackage

// File: rtl/mmac_ctrl.sv
module mmac_ctrl
  import mmac_pkg::*;
#(
  parameter int M      = 4,
  parameter int N      = 4,
  parameter int KSTEPS = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  output logic    outLast,
  output strobe_t st
);

  localparam int MN = M * N;
  localparam int KW = (KSTEPS > 1) ? $clog2(KSTEPS) : 1;

  typedef enum logic [2:0] {ST_C, ST_A, ST_B, ST_ACC, ST_OUT} state_e;

  state_e           state;
  logic [IDX_W-1:0] cnt;
  logic [KW-1:0]    kCnt;
  logic             fire;
  logic             lastC, lastA, lastB, lastOut, lastK;

  assign lastC   = (cnt == IDX_W'(MN - 1));
  assign lastA   = (cnt == IDX_W'(M - 1));
  assign lastB   = (cnt == IDX_W'(N - 1));
  assign lastOut = lastC;
  assign lastK   = (kCnt == KW'(KSTEPS - 1));

  always_comb begin
    inReady  = (state == ST_C) || (state == ST_A) || (state == ST_B);
    fire     = inValid && inReady;
    outValid = (state == ST_OUT);
    outLast  = outValid && lastOut;
    st           = '0;
    st.idx       = cnt;
    st.latchMode = (state == ST_C) && fire && (cnt == '0);
    st.loadC     = (state == ST_C) && fire;
    st.capA      = (state == ST_A) && fire;
    st.capB      = (state == ST_B) && fire;
    st.accum     = (state == ST_ACC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_C;
      cnt   <= '0;
      kCnt  <= '0;
    end else begin
      case (state)
        ST_C: if (fire) begin
          cnt   <= lastC ? '0 : cnt + 1'b1;
          if (lastC) state <= ST_A;
        end
        ST_A: if (fire) begin
          cnt   <= lastA ? '0 : cnt + 1'b1;
          if (lastA) state <= ST_B;
        end
        ST_B: if (fire) begin
          cnt   <= lastB ? '0 : cnt + 1'b1;
          if (lastB) state <= ST_ACC;
        end
        ST_ACC: begin
          kCnt  <= lastK ? '0 : kCnt + 1'b1;
          state <= lastK ? ST_OUT : ST_A;
        end
        ST_OUT: if (outReady) begin
          cnt   <= lastOut ? '0 : cnt + 1'b1;
          if (lastOut) state <= ST_C;
        end
        default: state <= ST_C;
      endcase
    end
  end

  // R9
  input_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R8
  last_ends_tile_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (!outValid && inReady));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLast)));

endmodule

// File: rtl/mmac_dpath.sv
module mmac_dpath
  import mmac_pkg::*;
#(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic [1:0]  mode,
  input  logic [31:0] inData,
  output logic [31:0] outData
);

  localparam int MN = M * N;

  logic [1:0]  modeReg;
  logic [31:0] aW   [M];
  logic [31:0] bW   [N];
  logic [31:0] accArr [MN];
  logic [31:0] dots [MN];

  for (genvar gi = 0; gi < M; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      assign dots[gi*N+gj] = dotWord(modeReg, aW[gi], bW[gj]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      for (int i = 0; i < M; i++)  aW[i] <= '0;
      for (int j = 0; j < N; j++)  bW[j] <= '0;
      for (int k = 0; k < MN; k++) accArr[k] <= '0;
    end else begin
      if (st.latchMode) modeReg <= mode;
      for (int i = 0; i < M; i++)
        if (st.capA && st.idx == IDX_W'(i)) aW[i] <= inData;
      for (int j = 0; j < N; j++)
        if (st.capB && st.idx == IDX_W'(j)) bW[j] <= inData;
      for (int k = 0; k < MN; k++) begin
        if (st.loadC && st.idx == IDX_W'(k)) accArr[k] <= inData;
        else if (st.accum)                    accArr[k] <= accArr[k] + dots[k];
      end
    end
  end

  always_comb begin
    outData = '0;
    for (int k = 0; k < MN; k++)
      if (st.idx == IDX_W'(k)) outData = accArr[k];
  end

  for (genvar gk = 0; gk < MN; gk++) begin : g_chk
    // R5
    c_preload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (st.loadC && st.idx == IDX_W'(gk)) |=> (accArr[gk] == $past(inData)));
  end

  // R4
  binary_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.accum && modeReg[1]) |=> ((accArr[0] - $past(accArr[0])) <= 32'd32));

endmodule

// File: rtl/mmac_tile.sv
module mmac_tile #(
  parameter int M      = 4,
  parameter int N      = 4,
  parameter int KSTEPS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic [31:0] inData,
  input  logic        inValid,
  output logic        inReady,
  output logic [31:0] outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        outLast
);

  mmac_pkg::strobe_t st;

  mmac_ctrl #(.M(M), .N(N), .KSTEPS(KSTEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .st(st)
  );

  mmac_dpath #(.M(M), .N(N)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .mode(mode),
    .inData(inData), .outData(outData)
  );

  // R10
  out_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/mmac_tile_bench.sv
module mmac_tile_bench;
  localparam int M = 2, N = 2, KS = 2, MN = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0]  mode;
  logic [31:0] inData, outData;
  logic inValid, inReady, outValid, outReady, outLast;

  always #5 clk = ~clk;

  mmac_tile #(.M(M), .N(N), .KSTEPS(KS)) u_mmac_tile (
    .clk(clk), .rstN(rstN), .mode(mode), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast)
  );

  int total = 0, bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] cA [MN];
  logic [31:0] aA [KS][M];
  logic [31:0] bA [KS][N];

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int elem(input logic [31:0] w, input int bits, input int e);
    int x;
    x = int'((w >> (bits * e)) & ((32'd1 << bits) - 1));
    if (x >= (1 << (bits - 1))) x = x - (1 << bits);
    return x;
  endfunction

  function automatic logic [31:0] dotRef(input int md, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [31:0] s = 0;
    if (md == 0)      for (int e = 0; e < 4; e++)  s += 32'(elem(a, 8, e) * elem(b, 8, e));
    else if (md == 1) for (int e = 0; e < 8; e++)  s += 32'(elem(a, 4, e) * elem(b, 4, e));
    else              for (int e = 0; e < 32; e++) s += 32'(a[e] & b[e]);
    return s;
  endfunction

  task automatic pushWord(input logic [31:0] w, input logic [1:0] md);
    @(negedge clk);
    inValid = 1'b1; inData = w; mode = md;
    while (!inReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic runTile(input int md, input string req);
    logic [31:0] exp [MN];
    logic [31:0] held;
    logic [1:0]  alt;
    alt = 2'(md ^ 1);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++) begin
        exp[i*N+j] = cA[i*N+j];
        for (int k = 0; k < KS; k++) exp[i*N+j] += dotRef(md, aA[k][i], bA[k][j]);
      end
    // first C word carries the mode; later words offer another mode (R11)
    for (int c = 0; c < MN; c++) pushWord(cA[c], (c == 0) ? 2'(md) : alt);
    for (int k = 0; k < KS; k++) begin
      for (int i = 0; i < M; i++) pushWord(aA[k][i], alt);
      for (int j = 0; j < N; j++) pushWord(bA[k][j], alt);
    end
    @(negedge clk);
    inValid = 1'b1; inData = 32'hDEAD_BEEF; mode = alt;  // stray offer (R9)
    for (int e = 0; e < MN; e++) begin
      @(negedge clk);
      if (e == 1) begin
        outReady = 1'b0;
        while (!outValid) @(negedge clk);
        held = outData;
        @(negedge clk);
        chk(outValid && outData == held, "R10 stall hold", outData, held);
      end
      outReady = 1'b1;
      while (!outValid) @(negedge clk);
      chk(!inReady, "R9 input closed during output", 32'(inReady), 32'd0);
      chk(outData == exp[e], req, outData, exp[e]);
      chk(outLast == (e == MN - 1), "R8 last flag", 32'(outLast), 32'(e == MN - 1));
      @(posedge clk);
    end
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b0;
  endtask

  task automatic fillRand();
    for (int c = 0; c < MN; c++) cA[c] = nextRand();
    for (int k = 0; k < KS; k++) begin
      for (int i = 0; i < M; i++) aA[k][i] = nextRand();
      for (int j = 0; j < N; j++) bA[k][j] = nextRand();
    end
  endtask

  task automatic fillConst(input logic [31:0] c, input logic [31:0] a, input logic [31:0] b);
    for (int x = 0; x < MN; x++) cA[x] = c;
    for (int k = 0; k < KS; k++) begin
      for (int i = 0; i < M; i++) aA[k][i] = a;
      for (int j = 0; j < N; j++) bA[k][j] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = '0; mode = '0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(!outValid, "R1 reset outValid", 32'(outValid), 32'd0);
    chk(inReady, "R1 reset inReady", 32'(inReady), 32'd1);

    // R5: zero operands leave C untouched
    fillRand(); fillConst(32'h0, 32'h0, 32'h0);
    for (int c = 0; c < MN; c++) cA[c] = nextRand();
    runTile(0, "R5 C preload");

    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 4; r++) begin
        fillRand();
        runTile(md, md == 0 ? "R2/R6/R11 int8" : md == 1 ? "R3/R6/R11 int4" : "R4/R6/R11 binary");
      end
    end

    // extremes per precision
    fillConst(32'h5, 32'h8080_8080, 32'h8080_8080); runTile(0, "R2 int8 extreme");
    fillConst(32'h5, 32'h7F80_7F80, 32'h807F_807F); runTile(0, "R2 int8 mixed");
    fillConst(32'h0, 32'h8888_8888, 32'h8888_8888); runTile(1, "R3 int4 extreme");
    fillConst(32'h0, 32'h7878_7878, 32'h8787_8787); runTile(1, "R3 int4 mixed");
    fillConst(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); runTile(2, "R4 binary full");
    fillConst(32'h3, 32'hAAAA_AAAA, 32'h5555_5555); runTile(3, "R4 binary disjoint");

    // R7: wrap past the positive limit
    fillConst(32'h7FFF_FFF0, 32'h8080_8080, 32'h8080_8080); runTile(0, "R7 wrap");
    fillConst(32'h8000_0000, 32'h7F7F_7F7F, 32'h8080_8080); runTile(0, "R7 wrap negative");

    finishRun();
  end
endmodule